// File: doc/BRIEF.md
# Nine-Bit Three-Wire Command Serializer

This block writes registers in a display controller over a three-wire serial link. The link has an active-low select, a serial clock and a data-out line. A fourth line, data-in, carries the wire state back to the block. A request gives an 8-bit register address and zero, one or two data bytes.

The block turns each byte into a 9-bit word. The top bit of the word says whether it carries the register address or a data byte. It then shifts all words of the request out, most significant bit first, under a single select assertion. When two data bytes are sent, the high byte goes first.

While each bit is driven, the block compares the data-in line with the bit it is driving. On the first disagreement it abandons the transfer, returns the link to idle and reports an error. A parameter, counted in system clocks, sets the length of each half of the serial clock period. Its default gives roughly 200 µs at a 50 MHz system clock, which respects the slow minimum clock cycle of such controllers.

Top module: `cmd9_serializer`

## Requirements
- R1: Every word is 9 bits long. Bit 8 is 0 for the address word and 1 for each data word. Bits 7:0 carry the address or the data byte.
- R2: `len_i` selects the number of data bytes. 0 sends the address word only. 1 sends the address word and then `data_i[7:0]`. 2 sends the address word, then `data_i[15:8]`, then `data_i[7:0]`. The value 3 behaves exactly like 2.
- R3: `ser_cs_no` falls in the cycle after a request is accepted. It stays low without a gap across every word of the transfer and rises only in the cycle where `done_o` pulses.
- R4: Bits leave most significant first. For each bit, `ser_clk_o` is low for `HALF_CYCLES` system clocks and then high for `HALF_CYCLES` system clocks. `ser_do_o` changes only on the falling edge of the serial clock.
- R5: After reset and whenever idle, `ser_cs_no` = 1, `ser_clk_o` = 1, `ser_do_o` = 0, `busy_o` = 0 and `done_o` = 0.
- R6: `ser_di_i` is sampled in the last system clock of each low half-period. On a mismatch with the driven bit, the next cycle has select high, serial clock high, data-out low, and `done_o` and `err_o` both high for one cycle. No further serial clock rise follows.
- R7: After the high half of the last bit, select rises and `done_o` pulses for exactly one cycle with `err_o` = 0.
- R8: A request (`req_i` = 1) is taken only when `busy_o` = 0. `busy_o` is high from the cycle after acceptance up to the cycle before `done_o`. A request raised while busy is ignored and does not change the current transfer. A request held high across `done_o` starts the next transfer in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer when idle |
| len_i | input | 2 | Data byte count (0, 1, 2; 3 acts as 2) |
| addr_i | input | 8 | Register address |
| data_i | input | 16 | Data bytes; high byte used only for two-byte writes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |
| err_o | output | 1 | Valid with `done_o`: loopback mismatch |
| ser_cs_no | output | 1 | Serial select, active low |
| ser_clk_o | output | 1 | Serial clock, idles high |
| ser_do_o | output | 1 | Serial data out |
| ser_di_i | input | 1 | Returned data line, checked against `ser_do_o` |

## Verification
The hardest behaviour to provoke is an abort at a chosen bit position. Only a mismatch on the returned line ends a transfer early, and the bit where that happens depends on the word contents. The bench switches the returned line between a true loopback and a line held at 0 or at 1. It then picks addresses and data so that the first disagreement lands on bit 0, in the middle of the address word, or on the flag bit of the first data word. A reference model checks the exact cycle of each abort, and a count of serial clock rises confirms the position. Requests raised during a transfer, and a request held high across `done_o`, cover the acceptance rules.

// File: rtl/cmd9_pkg.sv
package cmd9_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } ser_phase_e;
endpackage

// File: rtl/cmd9_framer.sv
module cmd9_framer #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 2,
  localparam int WORD_W   = BYTE_W + 1,
  localparam int NWORDS   = MAX_BYTES + 1,
  localparam int FRAME_W  = WORD_W * NWORDS,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int BITS_W   = $clog2(FRAME_W + 1)
) (
  input  logic [BYTE_W-1:0]           addr_i,
  input  logic [BYTE_W*MAX_BYTES-1:0] data_i,
  input  logic [LEN_W-1:0]            len_i,
  output logic [FRAME_W-1:0]          frame_o,
  output logic [BITS_W-1:0]           nbits_o
);
  logic [LEN_W-1:0]  n_eff;
  logic [BYTE_W-1:0] byte_a [MAX_BYTES];

  // lengths above the maximum clamp to the maximum
  assign n_eff   = (len_i > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len_i;
  assign nbits_o = BITS_W'(WORD_W) * (BITS_W'(n_eff) + BITS_W'(1));

  // address word: flag 0
  assign frame_o[FRAME_W-1 -: WORD_W] = {1'b0, addr_i};

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_bytes
    assign byte_a[b] = data_i[b*BYTE_W +: BYTE_W];
  end

  // data word k carries byte (n_eff-1-k): high byte leaves first
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_words
    logic [WORD_W-1:0] word_k;
    logic [LEN_W-1:0]  sel_k;
    always_comb begin
      word_k = '0;
      sel_k  = n_eff - LEN_W'(k) - LEN_W'(1);
      if (LEN_W'(k) < n_eff) word_k = {1'b1, byte_a[sel_k]};
    end
    assign frame_o[FRAME_W-1-(k+1)*WORD_W -: WORD_W] = word_k;
  end
endmodule

// File: rtl/cmd9_half_timer.sv
module cmd9_half_timer #(
  parameter int HALF_CYCLES = 10000,
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(HALF_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(HALF_CYCLES));
  // R4
  cnt_idle_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/cmd9_shift_ctrl.sv
module cmd9_shift_ctrl
  import cmd9_pkg::*;
#(
  parameter int FRAME_W = 27,
  parameter int BITS_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BITS_W-1:0]  nbits_i,
  input  logic               tick_i,
  input  logic               sdi_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               sdo_o
);
  ser_phase_e        state_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [BITS_W-1:0]  left_q;

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      cs_no   <= 1'b1;
      sclk_o  <= 1'b1;
      sdo_o   <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_LOW;
          cs_no   <= 1'b0;
          sclk_o  <= 1'b0;
          sdo_o   <= frame_i[FRAME_W-1];
          shreg_q <= frame_i << 1;
          left_q  <= nbits_i - BITS_W'(1);
        end
        ST_LOW: if (tick_i) begin
          if (sdi_i != sdo_o) begin
            // loopback mismatch: drop to idle bus at once
            state_q <= ST_IDLE;
            cs_no   <= 1'b1;
            sclk_o  <= 1'b1;
            sdo_o   <= 1'b0;
            done_o  <= 1'b1;
            err_o   <= 1'b1;
          end else begin
            state_q <= ST_HIGH;
            sclk_o  <= 1'b1;
          end
        end
        ST_HIGH: if (tick_i) begin
          if (left_q == '0) begin
            state_q <= ST_IDLE;
            cs_no   <= 1'b1;
            sdo_o   <= 1'b0;
            done_o  <= 1'b1;
          end else begin
            state_q <= ST_LOW;
            sclk_o  <= 1'b0;
            sdo_o   <= shreg_q[FRAME_W-1];
            shreg_q <= shreg_q << 1;
            left_q  <= left_q - BITS_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && sclk_o && !sdo_o));
  // R4
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o) |-> $stable(sdo_o));
  // R3
  cs_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);
  // R6
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> (busy_o && !cs_no));
endmodule

// File: rtl/cmd9_serializer.sv
module cmd9_serializer #(
  parameter int HALF_CYCLES = 10000,
  parameter int BYTE_W      = 8,
  parameter int MAX_BYTES   = 2,
  localparam int WORD_W     = BYTE_W + 1,
  localparam int FRAME_W    = WORD_W * (MAX_BYTES + 1),
  localparam int LEN_W      = $clog2(MAX_BYTES + 1),
  localparam int BITS_W     = $clog2(FRAME_W + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [LEN_W-1:0]            len_i,
  input  logic [BYTE_W-1:0]           addr_i,
  input  logic [BYTE_W*MAX_BYTES-1:0] data_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic                        ser_cs_no,
  output logic                        ser_clk_o,
  output logic                        ser_do_o,
  input  logic                        ser_di_i
);
  logic [FRAME_W-1:0] frame;
  logic [BITS_W-1:0]  nbits;
  logic               tick;

  cmd9_framer #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) framer_i (
    .addr_i (addr_i),
    .data_i (data_i),
    .len_i  (len_i),
    .frame_o(frame),
    .nbits_o(nbits)
  );

  cmd9_half_timer #(.HALF_CYCLES(HALF_CYCLES)) timer_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .tick_o(tick)
  );

  cmd9_shift_ctrl #(.FRAME_W(FRAME_W), .BITS_W(BITS_W)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .frame_i(frame),
    .nbits_i(nbits),
    .tick_i (tick),
    .sdi_i  (ser_di_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .err_o  (err_o),
    .cs_no  (ser_cs_no),
    .sclk_o (ser_clk_o),
    .sdo_o  (ser_do_o)
  );
endmodule

// File: tb/cmd9_serializer_tb_top.sv
`timescale 1ns/1ps
module cmd9_serializer_tb_top;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] len = '0;
  logic [7:0] addr = '0;
  logic [15:0] data = '0;
  logic busy, done, err, cs_n, sclk, sdo, sdi;
  int sdi_mode = 0; // 0 loopback, 1 held low, 2 held high

  always #10 clk = ~clk;

  assign sdi = (sdi_mode == 0) ? sdo : (sdi_mode == 1) ? 1'b0 : 1'b1;

  cmd9_serializer #(.HALF_CYCLES(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .len_i(len), .addr_i(addr),
    .data_i(data), .busy_o(busy), .done_o(done), .err_o(err),
    .ser_cs_no(cs_n), .ser_clk_o(sclk), .ser_do_o(sdo), .ser_di_i(sdi));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- reference model ----------------
  bit m_bits[$];
  bit m_act = 0, m_low = 0;
  int m_cnt = 0, m_idx = 0;
  bit e_cs = 1, e_sclk = 1, e_sdo = 0, e_done = 0, e_err = 0;

  function automatic void push_word(bit flag, logic [7:0] b);
    m_bits.push_back(flag);
    for (int i = 7; i >= 0; i--) m_bits.push_back(b[i]);
  endfunction

  function automatic void m_end(bit fault);
    m_act = 0; e_cs = 1; e_sclk = 1; e_sdo = 0; e_done = 1; e_err = fault;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_low = 0; m_cnt = 0; m_idx = 0;
      e_cs = 1; e_sclk = 1; e_sdo = 0; e_done = 0; e_err = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (!m_act) begin
        if (req) begin
          m_bits.delete();
          push_word(1'b0, addr);
          if (len == 1) push_word(1'b1, data[7:0]);
          if (len >= 2) begin push_word(1'b1, data[15:8]); push_word(1'b1, data[7:0]); end
          m_act = 1; m_low = 1; m_cnt = 0; m_idx = 0;
          e_cs = 0; e_sclk = 0; e_sdo = m_bits[0];
        end
      end else if (m_cnt == HALF - 1) begin
        m_cnt = 0;
        if (m_low) begin
          if (sdi !== m_bits[m_idx]) m_end(1'b1);
          else begin m_low = 0; e_sclk = 1; end
        end else if (m_idx == m_bits.size() - 1) m_end(1'b0);
        else begin
          m_idx++; m_low = 1; e_sclk = 0; e_sdo = m_bits[m_idx];
        end
      end else m_cnt++;
    end
  end

  // ---------------- per-cycle compare and edge counters ----------------
  int rises = 0, last_rises = 0, done_cnt = 0;
  bit last_err = 0, prev_sclk = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R5 reset state
      check(cs_n === 1'b1 && sclk === 1'b1 && sdo === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R5", {cs_n, sclk, sdo, busy, done}, 5'b11000);
    end else begin
      check(cs_n === e_cs, "R3", cs_n, e_cs);
      check(sclk === e_sclk, "R4", sclk, e_sclk);
      check(sdo === e_sdo, "R1", sdo, e_sdo);
      check(busy === m_act, "R8", busy, m_act);
      check(done === e_done, "R7", done, e_done);
      check(err === e_err, "R6", err, e_err);
      if (sclk && !prev_sclk && !cs_n) rises++;
      if (done) begin
        last_rises = rises; last_err = err; rises = 0; done_cnt++;
      end
    end
    prev_sclk = sclk;
  end

  // ---------------- stimulus ----------------
  task automatic wait_done();
    int start = done_cnt;
    while (done_cnt == start) begin @(negedge clk); #1; end
  endtask

  task automatic run_txn(input logic [1:0] l, input logic [7:0] a, input logic [15:0] d,
                         input int exp_rises, input bit exp_err, input string rq);
    @(negedge clk);
    req = 1; len = l; addr = a; data = d;
    @(negedge clk);
    req = 0;
    wait_done();
    check(last_rises == exp_rises, rq, last_rises, exp_rises);
    check(last_err == exp_err, exp_err ? "R6" : "R7", last_err, exp_err);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 lengths, R1 framing, R4 timing under loopback
    run_txn(2'd0, 8'h29, 16'h0000, 9,  1'b0, "R2");
    run_txn(2'd1, 8'h3A, 16'hAB60, 18, 1'b0, "R2");
    run_txn(2'd2, 8'hB8, 16'hFFF9, 27, 1'b0, "R2");
    run_txn(2'd3, 8'hC3, 16'h2040, 27, 1'b0, "R2");

    // R6 aborts at chosen bit positions
    sdi_mode = 2; run_txn(2'd0, 8'h10, 16'h0000, 0, 1'b1, "R6");
    sdi_mode = 1; run_txn(2'd0, 8'h3B, 16'h0000, 3, 1'b1, "R6");
    sdi_mode = 1; run_txn(2'd1, 8'h00, 16'h0000, 9, 1'b1, "R6");
    sdi_mode = 0;

    // R8 request while busy ignored
    d0 = done_cnt;
    @(negedge clk); req = 1; len = 0; addr = 8'h11;
    @(negedge clk); req = 0;
    repeat (20) @(negedge clk);
    req = 1; len = 2; addr = 8'hAA; data = 16'h5533;
    repeat (2) @(negedge clk);
    req = 0;
    wait_done();
    check(last_rises == 9, "R8", last_rises, 9);
    repeat (40) @(negedge clk);
    check(done_cnt == d0 + 1, "R8", done_cnt - d0, 1);

    // R8 request held across done: back-to-back transfers
    d0 = done_cnt;
    @(negedge clk); req = 1; len = 1; addr = 8'hBD; data = 16'h0004;
    wait_done();
    check(busy === 1'b0, "R8", busy, 0);
    @(negedge clk); req = 0;
    check(busy === 1'b1, "R8", busy, 1);
    wait_done();
    check(done_cnt == d0 + 2 && last_rises == 18, "R8", done_cnt - d0, 2);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule